// File: doc/BRIEF.md
# Serial Input Edge Event Detector

This block sits behind a serial scan engine that captures up to 64 remote input bits, arranged as 8 banks of 8. Each time the engine finishes a frame it presents the fresh input vector together with a one-cycle frame-done pulse. The block compares every bit against its value in the previous frame. Each bit has a 2-bit edge selector that decides whether a rising edge, a falling edge, both or neither produce an event.

Events are latched into per-bank status bytes that software clears by writing ones. All status bits are ORed into one interrupt line. A small register bus gives access to the edge selectors and the status bytes. An input gives the number of banks that actually carry inputs; banks beyond that count never produce events. While the interface enable is low, software rewrites the selectors safely. The first frame after the enable comes back only refills the history.

Top module: `sio_edge_evt`

## Requirements
- R1: Pin b of bank n uses selector bits [2b+1:2b] of the bank's 16-bit selector register. Selector bit 0 set makes a 0-to-1 change between two successive frames set that pin's status bit.
- R2: Selector bit 1 set makes a 1-to-0 change set the status bit. Value 3 reacts to both directions. Value 0 reacts to neither.
- R3: The selector of bank n reads and writes as 16 bits at address 0x10+2n. The status of bank n reads at address 0x20+n in bits [7:0], with bits [15:8] zero. Every other address reads zero.
- R4: A write to a status address clears each status bit whose write-data bit is 1 and leaves the bits whose write-data bit is 0 unchanged.
- R5: When a clear and a new event hit the same status bit in the same cycle, the bit ends up set.
- R6: irq_o is high exactly when at least one status bit in any bank is set, starting in the cycle after the status changes.
- R7: Status bits are set only by a frame-done pulse that arrives while en_i is high. A frame-done pulse while en_i is low changes nothing.
- R8: The first frame after reset, and the first frame after en_i returns high, only loads the history and sets no status bit.
- R9: Banks with index n >= in_banks_i never set status. Values of in_banks_i above 8 act as 8.
- R10: After reset all selectors and status bits are zero and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Interface enable; low suspends detection and drops the history |
| frame_done_i | input | 1 | One-cycle pulse when a new input frame is valid |
| in_data_i | input | 64 | Captured input bits, bank n in bits [8n+7:8n] |
| in_banks_i | input | 4 | Number of banks that carry inputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register address |
| reg_wdata_i | input | 16 | Register write data (status writes use bits [7:0]) |
| reg_rdata_o | output | 16 | Register read data, combinational on reg_addr_i |
| irq_o | output | 1 | Combined event interrupt |

## Verification
A frame-done pulse or a register write applied before a clock edge shows up in the status bytes and in irq_o right after that edge, one register stage later. Read data depends only on the address and current state, so it is valid in the same cycle. The bench drives every input on the falling edge. A behavioural model updates on the rising edge, and irq_o and the read data are compared on the following falling edge, exactly one edge after the stimulus took effect. Simultaneous clear and event, disabled frames, the first frame after enable and the bank limit each get their own explicit expected values besides the model comparison.

// File: rtl/sio_evt_pkg.sv
package sio_evt_pkg;
  localparam logic [5:0] CFG_BASE = 6'h10;
  localparam logic [5:0] STS_BASE = 6'h20;

  typedef enum logic [1:0] {
    EV_OFF  = 2'b00,
    EV_RISE = 2'b01,
    EV_FALL = 2'b10,
    EV_BOTH = 2'b11
  } ev_sel_e;
endpackage

// File: rtl/sio_evt_cfg.sv
module sio_evt_cfg
  import sio_evt_pkg::*;
#(
  parameter int unsigned NB = 8,
  parameter int unsigned BW = 8,
  parameter int unsigned AW = 6,
  localparam int unsigned DW = 2 * BW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [NB*DW-1:0] cfg_o
);
  for (genvar n = 0; n < NB; n++) begin : g_bank
    localparam logic [AW-1:0] ADDR = AW'(CFG_BASE) + AW'(2 * n);
    logic [DW-1:0] cfg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    cfg_q <= '0;
      else if (we_i && addr_i == ADDR) cfg_q <= wdata_i;
    end
    assign cfg_o[n*DW +: DW] = cfg_q;
  end
endmodule

// File: rtl/sio_evt_detect.sv
module sio_evt_detect
  import sio_evt_pkg::*;
#(
  parameter int unsigned NB = 8,
  parameter int unsigned BW = 8,
  parameter int unsigned CW = 4,
  localparam int unsigned N  = NB * BW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            frame_i,
  input  logic [N-1:0]    data_i,
  input  logic [2*N-1:0]  cfg_i,
  input  logic [CW-1:0]   bank_cnt_i,
  output logic [N-1:0]    evt_o
);
  logic [N-1:0] prev_q;
  logic         primed_q;
  logic         live;

  // history refills on the first frame after reset or re-enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else if (!en_i) begin
      primed_q <= 1'b0;
    end else if (frame_i) begin
      prev_q   <= data_i;
      primed_q <= 1'b1;
    end
  end

  assign live = en_i & frame_i & primed_q;

  for (genvar n = 0; n < NB; n++) begin : g_bank
    logic bank_ok;
    assign bank_ok = (CW'(n) < bank_cnt_i);
    for (genvar b = 0; b < BW; b++) begin : g_bit
      localparam int unsigned IDX = n * BW + b;
      ev_sel_e sel;
      logic    rise, fall;
      assign sel  = ev_sel_e'(cfg_i[2*IDX +: 2]);
      assign rise = ~prev_q[IDX] &  data_i[IDX] & (sel == EV_RISE || sel == EV_BOTH);
      assign fall =  prev_q[IDX] & ~data_i[IDX] & (sel == EV_FALL || sel == EV_BOTH);
      assign evt_o[IDX] = live & bank_ok & (rise | fall);
    end
  end
endmodule

// File: rtl/sio_evt_status.sv
module sio_evt_status
  import sio_evt_pkg::*;
#(
  parameter int unsigned NB = 8,
  parameter int unsigned BW = 8,
  parameter int unsigned AW = 6,
  localparam int unsigned N = NB * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] wdata_i,
  input  logic [N-1:0]  evt_i,
  output logic [N-1:0]  sts_o,
  output logic          irq_o
);
  for (genvar n = 0; n < NB; n++) begin : g_bank
    localparam logic [AW-1:0] ADDR = AW'(STS_BASE) + AW'(n);
    logic [BW-1:0] sts_q, clr;
    assign clr = (we_i && addr_i == ADDR) ? wdata_i : '0;
    // set has priority over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sts_q <= '0;
      else         sts_q <= (sts_q & ~clr) | evt_i[n*BW +: BW];
    end
    assign sts_o[n*BW +: BW] = sts_q;
  end

  assign irq_o = |sts_o;
endmodule

// File: rtl/sio_edge_evt.sv
module sio_edge_evt
  import sio_evt_pkg::*;
#(
  parameter int unsigned NB = 8,
  parameter int unsigned BW = 8,
  parameter int unsigned AW = 6,
  localparam int unsigned N  = NB * BW,
  localparam int unsigned DW = 2 * BW,
  localparam int unsigned CW = $clog2(NB + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          frame_done_i,
  input  logic [N-1:0]  in_data_i,
  input  logic [CW-1:0] in_banks_i,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o
);
  logic [2*N-1:0] cfg_w;
  logic [N-1:0]   evt_w;
  logic [N-1:0]   sts_w;

  sio_evt_cfg #(.NB(NB), .BW(BW), .AW(AW)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .cfg_o   (cfg_w)
  );

  sio_evt_detect #(.NB(NB), .BW(BW), .CW(CW)) u_det (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .frame_i    (frame_done_i),
    .data_i     (in_data_i),
    .cfg_i      (cfg_w),
    .bank_cnt_i (in_banks_i),
    .evt_o      (evt_w)
  );

  sio_evt_status #(.NB(NB), .BW(BW), .AW(AW)) u_sts (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i[BW-1:0]),
    .evt_i   (evt_w),
    .sts_o   (sts_w),
    .irq_o   (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int n = 0; n < NB; n++) begin
      if (reg_addr_i == AW'(CFG_BASE) + AW'(2 * n)) reg_rdata_o = cfg_w[n*DW +: DW];
      if (reg_addr_i == AW'(STS_BASE) + AW'(n))     reg_rdata_o = DW'(sts_w[n*BW +: BW]);
    end
  end
endmodule

// File: rtl/sio_evt_chk.sv
module sio_evt_chk #(
  parameter int unsigned NB = 8,
  parameter int unsigned BW = 8,
  parameter int unsigned CW = 4,
  localparam int unsigned N = NB * BW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          frame_done_i,
  input logic          reg_we_i,
  input logic [CW-1:0] in_banks_i,
  input logic          irq_o,
  input logic [N-1:0]  sts_i
);
  logic         seen_q;
  logic [N-1:0] oor_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          seen_q <= 1'b0;
    else if (!en_i)       seen_q <= 1'b0;
    else if (frame_done_i) seen_q <= 1'b1;
  end

  always_comb begin
    oor_mask = '0;
    for (int n = 0; n < NB; n++)
      if (CW'(n) >= in_banks_i) oor_mask[n*BW +: BW] = '1;
  end

  assert_set_needs_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_i & ~$past(sts_i)) != '0) |-> $past(frame_done_i && en_i));

  assert_clear_needs_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~sts_i & $past(sts_i)) != '0) |-> $past(reg_we_i));

  assert_first_frame_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && frame_done_i && !seen_q) |=> ((sts_i & ~$past(sts_i)) == '0));

  assert_bank_limit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_i |=> (((sts_i & ~$past(sts_i)) & $past(oor_mask)) == '0));

  assert_irq_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(frame_done_i));

  assert_irq_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(reg_we_i));
endmodule

bind sio_edge_evt sio_evt_chk #(.NB(NB), .BW(BW), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .frame_done_i (frame_done_i),
  .reg_we_i     (reg_we_i),
  .in_banks_i   (in_banks_i),
  .irq_o        (irq_o),
  .sts_i        (sts_w)
);

// File: tb/sio_edge_evt_tb.sv
`timescale 1ns/1ps
module sio_edge_evt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        fd = 1'b0;
  logic [63:0] din = '0;
  logic [3:0]  nbank = 4'd8;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sio_edge_evt dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .frame_done_i(fd),
    .in_data_i(din), .in_banks_i(nbank), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  logic [15:0] m_cfg [8];
  logic [7:0]  m_sts [8];
  logic [63:0] m_prev;
  bit          m_primed;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < 8; n++) begin m_cfg[n] = '0; m_sts[n] = '0; end
      m_prev = '0; m_primed = 0;
    end else begin
      logic [7:0] ev [8];
      for (int n = 0; n < 8; n++) begin
        ev[n] = '0;
        for (int b = 0; b < 8; b++) begin
          int i;
          bit r, f;
          i = n * 8 + b;
          r = !m_prev[i] && din[i] && m_cfg[n][2*b];
          f = m_prev[i] && !din[i] && m_cfg[n][2*b+1];
          if (en && fd && m_primed && n < nbank && (r || f)) ev[n][b] = 1'b1;
        end
      end
      for (int n = 0; n < 8; n++) begin
        logic [7:0] clr;
        clr = (we && addr == 6'h20 + 6'(n)) ? wdata[7:0] : 8'h00;
        m_sts[n] = (m_sts[n] & ~clr) | ev[n];
        if (we && addr == 6'h10 + 6'(2 * n)) m_cfg[n] = wdata;
      end
      if (!en) m_primed = 0;
      else if (fd) begin m_prev = din; m_primed = 1; end
    end
  end

  function automatic bit m_any();
    bit a = 0;
    for (int n = 0; n < 8; n++) if (m_sts[n] != 0) a = 1;
    return a;
  endfunction

  // R6: irq compared every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (irq !== m_any()) begin
        bad++;
        $display("FAIL R6 irq got=%0b exp=%0b at %0t", irq, m_any(), $time);
      end
    end
  end

  task automatic rd(input logic [5:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #0.5;
    total++;
    if (rdata !== exp) begin
      bad++;
      $display("FAIL %s addr=%h got=%h exp=%h", tag, a, rdata, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic frame(input logic [63:0] d);
    @(negedge clk);
    fd = 1; din = d;
    @(negedge clk);
    fd = 0;
  endtask

  task automatic frame_wr(input logic [63:0] d, input logic [5:0] a, input logic [15:0] w);
    @(negedge clk);
    fd = 1; din = d; we = 1; addr = a; wdata = w;
    @(negedge clk);
    fd = 0; we = 0;
  endtask

  task automatic chk_model(input string tag);
    for (int n = 0; n < 8; n++) rd(6'h20 + 6'(n), {8'h00, m_sts[n]}, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state, R3 idle reads
    for (int n = 0; n < 8; n++) begin
      rd(6'h10 + 6'(2 * n), 16'h0000, "R10 cfg");
      rd(6'h20 + 6'(n), 16'h0000, "R10 sts");
    end
    // R1/R2: bank0 pin0 rise, pin1 fall, pin2 both, pin3 off
    wr(6'h10, 16'h0039);
    for (int n = 1; n < 8; n++) wr(6'h10 + 6'(2 * n), 16'hFFFF);
    rd(6'h10, 16'h0039, "R3 cfg readback");
    rd(6'h12, 16'hFFFF, "R3 cfg readback");
    rd(6'h11, 16'h0000, "R3 unmapped");
    rd(6'h00, 16'h0000, "R3 unmapped");
    en = 1;
    frame(64'h0);
    chk_model("R8 prime");
    rd(6'h20, 16'h0000, "R8 prime none");
    frame(64'h0F);
    rd(6'h20, 16'h0005, "R1 rising");
    frame(64'h00);
    rd(6'h20, 16'h0007, "R2 falling");
    wr(6'h20, 16'h0001);
    rd(6'h20, 16'h0006, "R4 clear one");
    wr(6'h20, 16'h0000);
    rd(6'h20, 16'h0006, "R4 write zero");
    frame(64'h01);
    frame(64'h00);
    rd(6'h20, 16'h0007, "R2 pin0 fall ignored");
    frame_wr(64'h01, 6'h20, 16'h0001);
    rd(6'h20, 16'h0007, "R5 set wins");
    wr(6'h20, 16'h00FF);
    rd(6'h20, 16'h0000, "R4 clear all");
    // R9 bank limit
    nbank = 4'd3;
    frame(64'hFFFF_FFFF_FFFF_FF01);
    rd(6'h21, 16'h00FF, "R9 bank in range");
    rd(6'h25, 16'h0000, "R9 bank out of range");
    chk_model("R9");
    for (int n = 0; n < 8; n++) wr(6'h20 + 6'(n), 16'h00FF);
    nbank = 4'd8;
    // R7 disabled frame ignored
    en = 0;
    @(negedge clk);
    frame(64'h0);
    chk_model("R7 disabled");
    rd(6'h23, 16'h0000, "R7 disabled");
    // R8 first frame after re-enable
    en = 1;
    frame(64'h0);
    rd(6'h23, 16'h0000, "R8 re-enable");
    frame(64'hFFFF_FFFF_FFFF_FFFF);
    rd(6'h23, 16'h00FF, "R7 enabled frame");
    chk_model("R7");
    // mixed patterns
    for (int k = 0; k < 60; k++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      if (k % 7 == 0) wr(6'h10 + 6'(2 * ($urandom % 8)), 16'($urandom));
      if (k % 5 == 0) nbank = 4'($urandom % 10);
      if (k % 3 == 0) frame_wr(d, 6'h20 + 6'($urandom % 8), 16'($urandom));
      else frame(d);
      if (k % 4 == 0) chk_model("R1 R2 R4 R9 mix");
    end
    chk_model("R1 R2 final");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule